// File: doc/BRIEF.md
# Thread-Block Dispatch Prefetch Controller

This block sits between a thread-block dispatcher and the memory system. Before a kernel starts, software loads a small region table through a write port. Each row names one contiguous array region. A row holds a base byte pointer, a two-bit kind tag, an element size in bytes, and two linear functions of the dispatching block's (x, y, z) index. One function gives the lowest element index the block will touch and the other gives the highest.

When the dispatcher offers a block, the controller latches the block's index. It then walks the valid rows in ascending row order. For each row it works out the byte range and issues one read request for every 64-byte line in that range, using a valid/ready handshake. A counter tracks outstanding reads. The block is held inactive until issuing has finished and every response has come back. The controller then pulses a release signal, and only after that does it accept the next block.

The controller is a six-state machine:
- `ST_IDLE` accepts a dispatch. It goes to `ST_INDEX` if a valid row exists and to `ST_RELEASE` if none does.
- `ST_INDEX` registers the row's minimum and maximum element indices and always moves to `ST_SPAN`.
- `ST_SPAN` registers the first and last line. It goes to `ST_ISSUE`, or, when the range is empty, to the next valid row's `ST_INDEX` or to `ST_DRAIN`.
- `ST_ISSUE` presents line requests. After the last line is accepted it goes to the next valid row's `ST_INDEX`, or to `ST_DRAIN` if no valid row is left.
- `ST_DRAIN` waits for the outstanding count to reach zero and then moves to `ST_RELEASE`.
- `ST_RELEASE` pulses release for one cycle and returns to `ST_IDLE`.

Top module: `pf_dispatch_prefetch`

## Requirements
- R1: A configuration write with `cfg_we` high stores all row fields and the row's valid flag in row `cfg_row` at the next clock edge. A later write to the same row replaces it, and a row written with `cfg_valid` low generates no traffic.
- R2: A row's minimum index is bx*lo_cx + by*lo_cy + bz*lo_cz + lo_off, truncated to 32 bits, where bx, by and bz are the block index latched at dispatch. The maximum index uses the hi_* coefficients and hi_off in the same way. For example, with lo_cx = hi_cx = 256, lo_off = 0, hi_off = 255 and all other coefficients zero, block bx covers indices bx*256 to bx*256+255.
- R3: A row's byte addresses are base + index*esize, taken modulo 2^32. The row issues one request per 64-byte line, in ascending line order. The first request is for the line holding the minimum address and the last is for the line holding the maximum address. `mem_req_addr` is the line address, with bits [5:0] equal to zero.
- R4: Rows are processed in ascending row number. Rows whose valid flag is clear issue nothing.
- R5: A valid row whose maximum-address line is below its minimum-address line issues no request.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` and `mem_req_kind` hold their values into the next cycle.
- R7: `disp_release` is asserted only after every accepted request of the current block has received its response. It is high for exactly one cycle per accepted dispatch.
- R8: If no row is valid when a dispatch is accepted, `disp_release` is high in the cycle right after acceptance and no request is issued.
- R9: After reset, `disp_ready` is 1 and both `mem_req_valid` and `disp_release` are 0. `disp_ready` is low from the cycle after a dispatch is accepted through the release cycle, and it is high again in the cycle after release.
- R10: Each request carries the kind tag of the row it belongs to on `mem_req_kind`.
- R11: A response may arrive in the same cycle as a request is accepted. Release still waits until the outstanding count, which rises by one per accepted request and falls by one per response, is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 3 | Row number to write |
| cfg_valid | input | 1 | Valid flag stored with the row |
| cfg_base | input | 32 | Region base byte address |
| cfg_kind | input | 2 | Kind tag forwarded with requests |
| cfg_esize | input | 8 | Element size in bytes |
| cfg_lo_cx | input | 16 | Minimum-index coefficient for x |
| cfg_lo_cy | input | 16 | Minimum-index coefficient for y |
| cfg_lo_cz | input | 16 | Minimum-index coefficient for z |
| cfg_lo_off | input | 32 | Minimum-index constant |
| cfg_hi_cx | input | 16 | Maximum-index coefficient for x |
| cfg_hi_cy | input | 16 | Maximum-index coefficient for y |
| cfg_hi_cz | input | 16 | Maximum-index coefficient for z |
| cfg_hi_off | input | 32 | Maximum-index constant |
| disp_valid | input | 1 | Dispatcher offers a block |
| disp_ready | output | 1 | Controller can accept a block |
| disp_bx | input | 16 | Block index x |
| disp_by | input | 16 | Block index y |
| disp_bz | input | 16 | Block index z |
| disp_release | output | 1 | One-cycle pulse: block may start |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Line-aligned byte address |
| mem_req_kind | output | 2 | Kind tag of the row |
| mem_rsp_valid | input | 1 | One read response returned |

## Verification
The request stream has no fixed latency relative to dispatch, so the bench drives and samples at the falling edge and counts a request as accepted when it sees `mem_req_valid` with the ready it has just driven. It compares that request with the next entry of a list computed from its own copy of the table. A response driven at a falling edge takes effect at the next rising edge. For that reason `disp_release` is checked at each falling edge against the bench's own count of unanswered requests, and it must never appear while that count is non-zero. With no valid row, release is due at the first falling edge after the accepting rising edge (R8). `disp_ready` is due high again one cycle after release, and requests stalled by low ready are compared with the previous cycle's values.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int PF_ADDR_W = 32;
    localparam int PF_IDX_W  = 32;
    localparam int PF_COEF_W = 16;
    localparam int PF_OFF_W  = 32;
    localparam int PF_SIZE_W = 8;
    localparam int PF_KIND_W = 2;
    localparam int PF_BIDX_W = 16;

    typedef struct packed {
        logic [PF_ADDR_W-1:0] base;
        logic [PF_KIND_W-1:0] kind;
        logic [PF_SIZE_W-1:0] esize;
        logic [PF_COEF_W-1:0] lo_cx;
        logic [PF_COEF_W-1:0] lo_cy;
        logic [PF_COEF_W-1:0] lo_cz;
        logic [PF_OFF_W-1:0]  lo_off;
        logic [PF_COEF_W-1:0] hi_cx;
        logic [PF_COEF_W-1:0] hi_cy;
        logic [PF_COEF_W-1:0] hi_cz;
        logic [PF_OFF_W-1:0]  hi_off;
    } pf_row_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INDEX,
        ST_SPAN,
        ST_ISSUE,
        ST_DRAIN,
        ST_RELEASE
    } pf_state_t;

endpackage

// File: rtl/pf_table.sv
module pf_table
    import pf_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic             wr_valid,
    input  pf_row_t          wr_data,
    input  logic [ROW_W-1:0] rd_row,
    output pf_row_t          rd_data,
    output logic [ROWS-1:0]  valid_mask
);

    pf_row_t rows_w [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        pf_row_t row_q;
        logic    vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q <= '0;
                vld_q <= 1'b0;
            end else if (wr_en && (wr_row == ROW_W'(g))) begin
                row_q <= wr_data;
                vld_q <= wr_valid;
            end
        end

        assign rows_w[g]     = row_q;
        assign valid_mask[g] = vld_q;
    end

    assign rd_data = rows_w[rd_row];

endmodule

// File: rtl/pf_row_pick.sv
module pf_row_pick #(
    parameter int ROWS = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic [ROWS-1:0]  mask,
    input  logic [ROW_W:0]   start,
    output logic             found,
    output logic [ROW_W-1:0] row
);

    // Lowest valid row at or above start; scanning downwards lets the lowest win.
    always_comb begin
        found = 1'b0;
        row   = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (mask[i] && ((ROW_W+1)'(i) >= start)) begin
                found = 1'b1;
                row   = ROW_W'(i);
            end
        end
    end

endmodule

// File: rtl/pf_index_eval.sv
module pf_index_eval
    import pf_pkg::*;
(
    input  pf_row_t              row,
    input  logic [PF_BIDX_W-1:0] bx,
    input  logic [PF_BIDX_W-1:0] by,
    input  logic [PF_BIDX_W-1:0] bz,
    output logic [PF_IDX_W-1:0]  lo_idx,
    output logic [PF_IDX_W-1:0]  hi_idx
);

    function automatic logic [PF_IDX_W-1:0] lin_index(
        input logic [PF_COEF_W-1:0] cx,
        input logic [PF_COEF_W-1:0] cy,
        input logic [PF_COEF_W-1:0] cz,
        input logic [PF_OFF_W-1:0]  off,
        input logic [PF_BIDX_W-1:0] x,
        input logic [PF_BIDX_W-1:0] y,
        input logic [PF_BIDX_W-1:0] z
    );
        logic [PF_IDX_W-1:0] px, py, pz;
        px = PF_IDX_W'(x) * PF_IDX_W'(cx);
        py = PF_IDX_W'(y) * PF_IDX_W'(cy);
        pz = PF_IDX_W'(z) * PF_IDX_W'(cz);
        return px + py + pz + PF_IDX_W'(off);
    endfunction

    assign lo_idx = lin_index(row.lo_cx, row.lo_cy, row.lo_cz, row.lo_off, bx, by, bz);
    assign hi_idx = lin_index(row.hi_cx, row.hi_cy, row.hi_cz, row.hi_off, bx, by, bz);

endmodule

// File: rtl/pf_line_span.sv
module pf_line_span
    import pf_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    localparam int LINE_SH = $clog2(LINE_BYTES),
    localparam int LINE_W  = PF_ADDR_W - LINE_SH
) (
    input  logic [PF_ADDR_W-1:0] base,
    input  logic [PF_SIZE_W-1:0] esize,
    input  logic [PF_IDX_W-1:0]  lo_idx,
    input  logic [PF_IDX_W-1:0]  hi_idx,
    output logic [LINE_W-1:0]    first_line,
    output logic [LINE_W-1:0]    last_line,
    output logic                 empty
);

    logic [PF_ADDR_W-1:0] lo_addr;
    logic [PF_ADDR_W-1:0] hi_addr;

    assign lo_addr    = base + PF_ADDR_W'(lo_idx * PF_IDX_W'(esize));
    assign hi_addr    = base + PF_ADDR_W'(hi_idx * PF_IDX_W'(esize));
    assign first_line = LINE_W'(lo_addr >> LINE_SH);
    assign last_line  = LINE_W'(hi_addr >> LINE_SH);
    assign empty      = last_line < first_line;

endmodule

// File: rtl/pf_outstanding.sv
module pf_outstanding #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign zero = (cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == {CNT_W{1'b1}}) |-> !(inc && !dec)); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !(dec && !inc)); // R11

endmodule

// File: rtl/pf_dispatch_prefetch.sv
module pf_dispatch_prefetch
    import pf_pkg::*;
#(
    parameter int ROWS       = 8,
    parameter int LINE_BYTES = 64,
    parameter int CNT_W      = 16,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int LINE_SH = $clog2(LINE_BYTES),
    localparam int LINE_W  = PF_ADDR_W - LINE_SH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ROW_W-1:0]     cfg_row,
    input  logic                 cfg_valid,
    input  logic [PF_ADDR_W-1:0] cfg_base,
    input  logic [PF_KIND_W-1:0] cfg_kind,
    input  logic [PF_SIZE_W-1:0] cfg_esize,
    input  logic [PF_COEF_W-1:0] cfg_lo_cx,
    input  logic [PF_COEF_W-1:0] cfg_lo_cy,
    input  logic [PF_COEF_W-1:0] cfg_lo_cz,
    input  logic [PF_OFF_W-1:0]  cfg_lo_off,
    input  logic [PF_COEF_W-1:0] cfg_hi_cx,
    input  logic [PF_COEF_W-1:0] cfg_hi_cy,
    input  logic [PF_COEF_W-1:0] cfg_hi_cz,
    input  logic [PF_OFF_W-1:0]  cfg_hi_off,
    input  logic                 disp_valid,
    output logic                 disp_ready,
    input  logic [PF_BIDX_W-1:0] disp_bx,
    input  logic [PF_BIDX_W-1:0] disp_by,
    input  logic [PF_BIDX_W-1:0] disp_bz,
    output logic                 disp_release,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PF_ADDR_W-1:0] mem_req_addr,
    output logic [PF_KIND_W-1:0] mem_req_kind,
    input  logic                 mem_rsp_valid
);

    pf_state_t state_q, state_d;

    logic [ROW_W-1:0]     row_ptr_q;
    logic [PF_BIDX_W-1:0] bx_q, by_q, bz_q;
    logic [PF_IDX_W-1:0]  lo_idx_q, hi_idx_q;
    logic [LINE_W-1:0]    cur_line_q, last_line_q;
    logic [PF_KIND_W-1:0] kind_q;

    pf_row_t          cfg_data;
    pf_row_t          row_rd;
    logic [ROWS-1:0]  valid_mask;
    logic [ROW_W:0]   pick_start;
    logic             pick_found;
    logic [ROW_W-1:0] pick_row;
    logic [PF_IDX_W-1:0] lo_idx_w, hi_idx_w;
    logic [LINE_W-1:0]   first_line_w, last_line_w;
    logic                span_empty;
    logic                req_fire;
    logic                last_fire;
    logic [CNT_W-1:0]    out_cnt;
    logic                out_zero;

    // ---------------- configuration table ----------------
    always_comb begin
        cfg_data        = '0;
        cfg_data.base   = cfg_base;
        cfg_data.kind   = cfg_kind;
        cfg_data.esize  = cfg_esize;
        cfg_data.lo_cx  = cfg_lo_cx;
        cfg_data.lo_cy  = cfg_lo_cy;
        cfg_data.lo_cz  = cfg_lo_cz;
        cfg_data.lo_off = cfg_lo_off;
        cfg_data.hi_cx  = cfg_hi_cx;
        cfg_data.hi_cy  = cfg_hi_cy;
        cfg_data.hi_cz  = cfg_hi_cz;
        cfg_data.hi_off = cfg_hi_off;
    end

    pf_table #(.ROWS(ROWS)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_row     (cfg_row),
        .wr_valid   (cfg_valid),
        .wr_data    (cfg_data),
        .rd_row     (row_ptr_q),
        .rd_data    (row_rd),
        .valid_mask (valid_mask)
    );

    // ---------------- next valid row ----------------
    assign pick_start = (state_q == ST_IDLE) ? '0
                      : ((ROW_W+1)'(row_ptr_q) + (ROW_W+1)'(1));

    pf_row_pick #(.ROWS(ROWS)) i_pick (
        .mask  (valid_mask),
        .start (pick_start),
        .found (pick_found),
        .row   (pick_row)
    );

    // ---------------- range datapath ----------------
    pf_index_eval i_index (
        .row    (row_rd),
        .bx     (bx_q),
        .by     (by_q),
        .bz     (bz_q),
        .lo_idx (lo_idx_w),
        .hi_idx (hi_idx_w)
    );

    pf_line_span #(.LINE_BYTES(LINE_BYTES)) i_span (
        .base       (row_rd.base),
        .esize      (row_rd.esize),
        .lo_idx     (lo_idx_q),
        .hi_idx     (hi_idx_q),
        .first_line (first_line_w),
        .last_line  (last_line_w),
        .empty      (span_empty)
    );

    // ---------------- outstanding reads ----------------
    assign req_fire  = mem_req_valid && mem_req_ready;
    assign last_fire = req_fire && (cur_line_q == last_line_q);

    pf_outstanding #(.CNT_W(CNT_W)) i_outstanding (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (req_fire),
        .dec   (mem_rsp_valid),
        .cnt   (out_cnt),
        .zero  (out_zero)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (disp_valid) state_d = pick_found ? ST_INDEX : ST_RELEASE;
            ST_INDEX:   state_d = ST_SPAN;
            ST_SPAN:    if (span_empty) state_d = pick_found ? ST_INDEX : ST_DRAIN;
                        else            state_d = ST_ISSUE;
            ST_ISSUE:   if (last_fire)  state_d = pick_found ? ST_INDEX : ST_DRAIN;
            ST_DRAIN:   if (out_zero)   state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        disp_ready    = (state_q == ST_IDLE);
        disp_release  = (state_q == ST_RELEASE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = {cur_line_q, {LINE_SH{1'b0}}};
        mem_req_kind  = kind_q;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_ptr_q   <= '0;
            bx_q        <= '0;
            by_q        <= '0;
            bz_q        <= '0;
            lo_idx_q    <= '0;
            hi_idx_q    <= '0;
            cur_line_q  <= '0;
            last_line_q <= '0;
            kind_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (disp_valid) begin
                        bx_q <= disp_bx;
                        by_q <= disp_by;
                        bz_q <= disp_bz;
                        if (pick_found) row_ptr_q <= pick_row;
                    end
                end
                ST_INDEX: begin
                    lo_idx_q <= lo_idx_w;
                    hi_idx_q <= hi_idx_w;
                end
                ST_SPAN: begin
                    cur_line_q  <= first_line_w;
                    last_line_q <= last_line_w;
                    kind_q      <= row_rd.kind;
                    if (span_empty && pick_found) row_ptr_q <= pick_row;
                end
                ST_ISSUE: begin
                    if (last_fire) begin
                        if (pick_found) row_ptr_q <= pick_row;
                    end else if (req_fire) begin
                        cur_line_q <= cur_line_q + LINE_W'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_kind)); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready |=> !disp_ready); // R9
    AST_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        disp_release |-> out_zero); // R7
    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_release |=> !disp_release && disp_ready); // R7
    AST_EMPTY_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready && (valid_mask == '0) |=> disp_release); // R8

endmodule

// File: tb/test_pf_dispatch_prefetch.sv
`timescale 1ns/1ps
module test_pf_dispatch_prefetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_row = '0;
    logic        cfg_valid = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [1:0]  cfg_kind = '0;
    logic [7:0]  cfg_esize = '0;
    logic [15:0] cfg_lo_cx = '0, cfg_lo_cy = '0, cfg_lo_cz = '0;
    logic [31:0] cfg_lo_off = '0;
    logic [15:0] cfg_hi_cx = '0, cfg_hi_cy = '0, cfg_hi_cz = '0;
    logic [31:0] cfg_hi_off = '0;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic [15:0] disp_bx = '0, disp_by = '0, disp_bz = '0;
    logic        disp_release;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [1:0]  mem_req_kind;
    logic        mem_rsp_valid = 1'b0;

    int tests = 0;
    int fails = 0;

    // bench copy of the table
    bit          m_valid [8];
    logic [31:0] m_base  [8];
    logic [1:0]  m_kind  [8];
    logic [7:0]  m_esize [8];
    logic [15:0] m_lcx [8], m_lcy [8], m_lcz [8];
    logic [15:0] m_hcx [8], m_hcy [8], m_hcz [8];
    logic [31:0] m_loff [8], m_hoff [8];
    logic [33:0] exp_q [$];

    always #2.5 clk = ~clk;

    pf_dispatch_prefetch i_pf_dispatch_prefetch (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_kind(cfg_kind), .cfg_esize(cfg_esize),
        .cfg_lo_cx(cfg_lo_cx), .cfg_lo_cy(cfg_lo_cy), .cfg_lo_cz(cfg_lo_cz),
        .cfg_lo_off(cfg_lo_off),
        .cfg_hi_cx(cfg_hi_cx), .cfg_hi_cy(cfg_hi_cy), .cfg_hi_cz(cfg_hi_cz),
        .cfg_hi_off(cfg_hi_off),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_bx(disp_bx), .disp_by(disp_by), .disp_bz(disp_bz),
        .disp_release(disp_release),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_kind(mem_req_kind),
        .mem_rsp_valid(mem_rsp_valid)
    );

    task automatic chk(input bit ok, input string req, input string detail);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    task automatic write_row(input int r, input bit v, input logic [31:0] base,
                             input logic [1:0] kind, input logic [7:0] esize,
                             input logic [15:0] lcx, lcy, lcz, input logic [31:0] loff,
                             input logic [15:0] hcx, hcy, hcz, input logic [31:0] hoff);
        @(negedge clk);
        cfg_we = 1'b1; cfg_row = 3'(r); cfg_valid = v;
        cfg_base = base; cfg_kind = kind; cfg_esize = esize;
        cfg_lo_cx = lcx; cfg_lo_cy = lcy; cfg_lo_cz = lcz; cfg_lo_off = loff;
        cfg_hi_cx = hcx; cfg_hi_cy = hcy; cfg_hi_cz = hcz; cfg_hi_off = hoff;
        m_valid[r] = v; m_base[r] = base; m_kind[r] = kind; m_esize[r] = esize;
        m_lcx[r] = lcx; m_lcy[r] = lcy; m_lcz[r] = lcz; m_loff[r] = loff;
        m_hcx[r] = hcx; m_hcy[r] = hcy; m_hcz[r] = hcz; m_hoff[r] = hoff;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R2 / R3 / R4 / R5 / R10 reference stream
    function automatic void build_expect(input logic [15:0] bx, by, bz);
        logic [31:0] lo, hi, la, ha, fl, ll;
        exp_q.delete();
        for (int r = 0; r < 8; r++) begin
            if (m_valid[r]) begin
                lo = 32'(bx) * 32'(m_lcx[r]) + 32'(by) * 32'(m_lcy[r])
                   + 32'(bz) * 32'(m_lcz[r]) + m_loff[r];
                hi = 32'(bx) * 32'(m_hcx[r]) + 32'(by) * 32'(m_hcy[r])
                   + 32'(bz) * 32'(m_hcz[r]) + m_hoff[r];
                la = m_base[r] + lo * 32'(m_esize[r]);
                ha = m_base[r] + hi * 32'(m_esize[r]);
                fl = la >> 6;
                ll = ha >> 6;
                if (ll >= fl)
                    for (logic [31:0] l = fl; l <= ll; l++) exp_q.push_back({m_kind[r], l << 6});
            end
        end
    endfunction

    function automatic bit any_valid();
        bit a = 1'b0;
        for (int r = 0; r < 8; r++) a |= m_valid[r];
        return a;
    endfunction

    task automatic run_dispatch(input logic [15:0] bx, by, bz, input string tag);
        int got = 0, bad = 0, pending = 0, cyc = 0, rel_cyc = -1, stab_bad = 0, rdy_bad = 0;
        bit released = 1'b0, prev_stall = 1'b0;
        logic [31:0] prev_addr = '0;
        logic [33:0] seen, first_act = '0, first_exp = '0;
        build_expect(bx, by, bz);
        @(negedge clk);
        chk(disp_ready == 1'b1, "R9", $sformatf("%s idle ready act=%0b exp=1", tag, disp_ready));
        disp_valid = 1'b1; disp_bx = bx; disp_by = by; disp_bz = bz;
        @(negedge clk);
        disp_valid = 1'b0;
        chk(disp_ready == 1'b0, "R9", $sformatf("%s ready after accept act=%0b exp=0", tag, disp_ready));
        while (!released && cyc < 30000) begin
            if (disp_release) begin
                released = 1'b1; rel_cyc = cyc;
                mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
            end else begin
                if (disp_ready) rdy_bad++;
                if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) stab_bad++;
                mem_rsp_valid = 1'b0;
                if (pending > 0 && ($urandom % 2) == 1) begin
                    mem_rsp_valid = 1'b1; pending--;
                end
                mem_req_ready = ($urandom % 3) != 0;
                if (mem_req_valid && mem_req_ready) begin
                    seen = {mem_req_kind, mem_req_addr};
                    if (got >= exp_q.size() || exp_q[got] != seen) begin
                        if (bad == 0) begin
                            first_act = seen;
                            first_exp = (got < exp_q.size()) ? exp_q[got] : '1;
                        end
                        bad++;
                    end
                    got++; pending++;
                end
                prev_stall = mem_req_valid && !mem_req_ready;
                prev_addr = mem_req_addr;
                @(negedge clk);
                cyc++;
            end
        end
        mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
        chk(released, "R7", $sformatf("%s release seen act=%0b exp=1", tag, released));
        // R11: same-cycle accept/response still leaves nothing owed at release
        chk(pending == 0, "R7", $sformatf("%s unanswered at release act=%0d exp=0", tag, pending));
        chk(got == exp_q.size(), "R3", $sformatf("%s request count act=%0d exp=%0d", tag, got, exp_q.size()));
        chk(bad == 0, "R10", $sformatf("%s kind/addr act=%h exp=%h (mismatches %0d)",
                                         tag, first_act, first_exp, bad));
        chk(stab_bad == 0, "R6", $sformatf("%s stall hold violations act=%0d exp=0", tag, stab_bad));
        chk(rdy_bad == 0, "R9", $sformatf("%s ready while busy act=%0d exp=0", tag, rdy_bad));
        if (!any_valid())
            chk(rel_cyc == 0 && got == 0, "R8",
                $sformatf("%s empty table release cycle act=%0d exp=0, requests %0d", tag, rel_cyc, got));
        @(negedge clk);
        chk(disp_ready == 1'b1 && disp_release == 1'b0, "R9",
            $sformatf("%s after release ready=%0b rel=%0b exp 1/0", tag, disp_ready, disp_release));
    endtask

    task automatic random_table();
        logic [31:0] lo;
        logic [15:0] a, b, c;
        for (int r = 0; r < 8; r++) begin
            a = 16'($urandom % 16); b = 16'($urandom % 16); c = 16'($urandom % 16);
            lo = 32'($urandom % 256);
            write_row(r, ($urandom % 4) != 0, $urandom & 32'h000F_FFFF, 2'($urandom),
                      8'(1 << ($urandom % 5)), a, b, c, lo,
                      a + 16'($urandom % 3), b + 16'($urandom % 3), c + 16'($urandom % 3),
                      (($urandom % 6) == 0 && lo >= 32'd60) ? lo - 32'd60 : lo + 32'($urandom % 200));
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R7: watchdog expired act=hung exp=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < 8; r++) m_valid[r] = 1'b0;
        repeat (3) @(negedge clk);
        chk(disp_ready == 1'b1, "R9", $sformatf("reset ready act=%0b exp=1", disp_ready));
        chk(mem_req_valid == 1'b0, "R9", $sformatf("reset req_valid act=%0b exp=0", mem_req_valid));
        chk(disp_release == 1'b0, "R9", $sformatf("reset release act=%0b exp=0", disp_release));
        rst_n = 1'b1;

        // R8: empty table
        run_dispatch(16'd1, 16'd0, 16'd0, "R8 empty");

        // R2: 256-element stride per block, 4-byte elements
        write_row(0, 1'b1, 32'h1000, 2'd1, 8'd4, 16'd256, 16'd0, 16'd0, 32'd0,
                  16'd256, 16'd0, 16'd0, 32'd255);
        run_dispatch(16'd2, 16'd0, 16'd0, "R2 stride");

        // R1: overwrite row 0 as invalid -> no traffic
        write_row(0, 1'b0, 32'h1000, 2'd1, 8'd4, 16'd256, 16'd0, 16'd0, 32'd0,
                  16'd256, 16'd0, 16'd0, 32'd255);
        run_dispatch(16'd2, 16'd0, 16'd0, "R1 overwrite");

        // R4 / R5: rows 1, 3 (empty range), 6; unaligned base, y and z terms
        write_row(6, 1'b1, 32'h0002_0010, 2'd3, 8'd8, 16'd0, 16'd5, 16'd0, 32'd3,
                  16'd0, 16'd5, 16'd1, 32'd20);
        write_row(3, 1'b1, 32'h0000_4000, 2'd2, 8'd2, 16'd0, 16'd0, 16'd0, 32'd100,
                  16'd0, 16'd0, 16'd0, 32'd10);
        write_row(1, 1'b1, 32'h0000_803C, 2'd0, 8'd1, 16'd1, 16'd1, 16'd1, 32'd0,
                  16'd1, 16'd1, 16'd1, 32'd130);
        run_dispatch(16'd3, 16'd4, 16'd2, "R4 order");

        // R3: single-element range (first line == last line)
        write_row(1, 1'b1, 32'h0000_0FFF, 2'd1, 8'd1, 16'd0, 16'd0, 16'd0, 32'd0,
                  16'd0, 16'd0, 16'd0, 32'd0);
        run_dispatch(16'd0, 16'd0, 16'd0, "R3 one line");

        // random tables and block indices
        for (int k = 0; k < 24; k++) begin
            if (k % 4 == 0) random_table();
            run_dispatch(16'($urandom % 8), 16'($urandom % 8), 16'($urandom % 8), "R3 random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule